// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Tracker

This block holds one load-linked reservation for a single processor data port. When the processor issues a load-linked access, the block records the physical address and drops any older reservation. When the first flit of the memory response arrives, the block stores the key carried in that flit and starts a lifetime down-counter. The reservation is live only while that counter is non-zero. No separate valid flag exists.

A later store-conditional asks the block for a local decision. If the reservation is live and the address matches, the block reports success and formats the two-flit command. The first flit carries the stored key and the second flit carries the store data. If the check fails, the store-conditional is refused locally and no bus transaction is made.

Three events cancel a live reservation: a local write to the reserved address, an atomic page-table or dirty-bit update to the reserved address, and an explicit software clear. The counter is updated with a fixed priority: a load takes precedence over a clear, and a clear takes precedence over a decrement.

Top module: `llsc_resv_tracker`

## Requirements
- R1: After a synchronous active-low reset, the counter is zero. `resv_live` is 0 and any store-conditional query fails.
- R2: An LL issue (`ll_issue_vld`) records `ll_issue_addr` as the reserved address. In the same cycle it clears any existing reservation, so `resv_live` is 0 on the next cycle.
- R3: A first-flit response (`ll_rsp_vld`) loads the counter with TIMEOUT. Without other events, `resv_live` then stays 1 for exactly TIMEOUT cycles and then reads 0.
- R4: A local write whose address equals the reserved address clears the reservation. A write to any other address has no effect.
- R5: An atomic update whose address equals the reserved address clears the reservation. An atomic update to any other address has no effect.
- R6: `sw_clr` clears the reservation in the cycle after it is asserted.
- R7: Counter priority is: load first, then clear, then decrement. A response that arrives in the same cycle as a matching write leaves a fresh reservation. A response that arrives while a reservation is live restarts the full lifetime.
- R8: `sc_ok` is 1 only when `sc_query_vld` is set, the reservation is live, and `sc_query_addr` equals the reserved address. Every other query raises `sc_fail`, and the two outputs are never 1 together.
- R9: The command fields are as follows. When `sc_flit_sel` is 0, `cmd_wdata` is the stored key. When `sc_flit_sel` is 1, `cmd_wdata` is `sc_data`. `cmd_addr` is `sc_query_addr` with bits [1:0] cleared, and `cmd_be` is 4'b1111.
- R10: `resv_key` holds the key of the latest response. Clear events and timeout do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_issue_vld | input | 1 | LL access issued this cycle |
| ll_issue_addr | input | PA_W | Physical address of the LL access |
| ll_rsp_vld | input | 1 | First response flit of the LL is present |
| ll_rsp_key | input | 32 | Key data carried in that flit |
| wr_vld | input | 1 | Local write issued |
| wr_addr | input | PA_W | Physical address of the local write |
| atom_vld | input | 1 | Atomic page-table or dirty-bit update issued |
| atom_addr | input | PA_W | Physical address of the atomic update |
| sw_clr | input | 1 | Software reservation clear |
| sc_query_vld | input | 1 | Store-conditional query |
| sc_query_addr | input | PA_W | Physical address of the store-conditional |
| sc_data | input | 32 | Store data for the second command flit |
| sc_flit_sel | input | 1 | Command flit select: 0 = key flit, 1 = data flit |
| sc_ok | output | 1 | Local store-conditional success |
| sc_fail | output | 1 | Local store-conditional failure |
| resv_live | output | 1 | Reservation currently live (counter non-zero) |
| resv_key | output | 32 | Stored reservation key |
| cmd_addr | output | PA_W | Word-aligned command address |
| cmd_wdata | output | 32 | Write data for the selected command flit |
| cmd_be | output | 4 | Command byte enables |

## Verification
If the lifetime counter is corrupted, `resv_live` and `sc_ok` go wrong on the very next cycle. This shows up either as an early expiry or as a reservation that outlives TIMEOUT by one cycle or more. The lifetime check counts cycles exactly to catch both.

A wrong reserved address shows at the next matching or non-matching query or write, so the bench probes the stored address with both kinds of access. A wrong priority shows when two events arrive in the same cycle: a cleared reservation appears where a fresh one was expected. A stale or wrong key shows in `cmd_wdata` on the key flit.

// File: rtl/llsc_pkg.sv
// Package: shared widths and types for the reservation tracker.
// Assumes a 32-bit key and data path.
package llsc_pkg;
    localparam int KEY_W = 32;
    localparam int BE_W  = KEY_W / 8;

    typedef logic [KEY_W-1:0] key_t;

    // Which flit of the store-conditional command is presented
    typedef enum logic {
        FLIT_KEY  = 1'b0,
        FLIT_DATA = 1'b1
    } flit_sel_e;
endpackage

// File: rtl/llsc_event_decode.sv
// Module: turns the port-side events into one load request and one clear
// request for the lifetime counter.
// Assumes the reserved address passed in is the registered one (before update).
module llsc_event_decode #(
    parameter int PA_W = 40
) (
    input  logic            ll_issue_vld,
    input  logic            ll_rsp_vld,
    input  logic            wr_vld,
    input  logic [PA_W-1:0] wr_addr,
    input  logic            atom_vld,
    input  logic [PA_W-1:0] atom_addr,
    input  logic            sw_clr,
    input  logic [PA_W-1:0] resv_addr,
    output logic            load_req,
    output logic            clr_req
);
    logic wr_hit;
    logic atom_hit;

    // Address-match detection for writes and atomic updates
    always_comb begin
        wr_hit   = wr_vld   && (wr_addr   == resv_addr);
        atom_hit = atom_vld && (atom_addr == resv_addr);
    end

    // Combine all cancelling sources; the load comes from the response flit
    always_comb begin
        load_req = ll_rsp_vld;
        clr_req  = ll_issue_vld || wr_hit || atom_hit || sw_clr;
    end
endmodule

// File: rtl/llsc_life_counter.sv
// Module: reservation lifetime down-counter. A reservation is live only while
// the count is non-zero. Priority: load, then clear, then decrement.
// Assumes TIMEOUT >= 1.
module llsc_life_counter #(
    parameter int unsigned TIMEOUT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_req,
    input  logic clr_req,
    output logic live
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] cnt_q;

    // Counter update under strict priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_req)
            cnt_q <= LOAD_VAL;
        else if (clr_req)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Liveness is purely the non-zero count
    always_comb live = (cnt_q != '0);

    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && load_req |=> cnt_q == LOAD_VAL);
    a_r7_clear_over_dec: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !load_req && clr_req |=> !live);
    a_r3_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !load_req && !clr_req && live |=> cnt_q == $past(cnt_q) - 1'b1);
    a_r1_idle_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !load_req && !live |=> !live);
endmodule

// File: rtl/llsc_sc_cmd.sv
// Module: local store-conditional decision and command flit formatting.
// Assumes the command address is word-aligned by clearing bits [1:0].
module llsc_sc_cmd
    import llsc_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            live,
    input  logic [PA_W-1:0] resv_addr,
    input  key_t            resv_key,
    input  logic            sc_query_vld,
    input  logic [PA_W-1:0] sc_query_addr,
    input  key_t            sc_data,
    input  flit_sel_e       sc_flit_sel,
    output logic            sc_ok,
    output logic            sc_fail,
    output logic [PA_W-1:0] cmd_addr,
    output key_t            cmd_wdata,
    output logic [BE_W-1:0] cmd_be
);
    logic addr_match;

    // Local success or fail decision
    always_comb begin
        addr_match = (sc_query_addr == resv_addr);
        sc_ok      = sc_query_vld && live && addr_match;
        sc_fail    = sc_query_vld && !(live && addr_match);
    end

    // Command fields: aligned address, full byte enables, flit data mux
    always_comb begin
        cmd_addr  = {sc_query_addr[PA_W-1:2], 2'b00};
        cmd_be    = '1;
        cmd_wdata = (sc_flit_sel == FLIT_KEY) ? resv_key : sc_data;
    end

    a_r8_ok_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> live);
    a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_ok && sc_fail));
    a_r8_query_decided: assert property (@(posedge clk) disable iff (!rst_n)
        sc_query_vld |-> (sc_ok || sc_fail));
endmodule

// File: rtl/llsc_resv_tracker.sv
// Module: top of the single-entry reservation tracker. Holds the reserved
// address and key registers, and connects the event decoder, the lifetime
// counter and the store-conditional formatter.
// Assumes at most one reservation per data port.
module llsc_resv_tracker
    import llsc_pkg::*;
#(
    parameter int          PA_W    = 40,
    parameter int unsigned TIMEOUT = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ll_issue_vld,
    input  logic [PA_W-1:0]  ll_issue_addr,
    input  logic             ll_rsp_vld,
    input  logic [KEY_W-1:0] ll_rsp_key,
    input  logic             wr_vld,
    input  logic [PA_W-1:0]  wr_addr,
    input  logic             atom_vld,
    input  logic [PA_W-1:0]  atom_addr,
    input  logic             sw_clr,
    input  logic             sc_query_vld,
    input  logic [PA_W-1:0]  sc_query_addr,
    input  logic [KEY_W-1:0] sc_data,
    input  logic             sc_flit_sel,
    output logic             sc_ok,
    output logic             sc_fail,
    output logic             resv_live,
    output logic [KEY_W-1:0] resv_key,
    output logic [PA_W-1:0]  cmd_addr,
    output logic [KEY_W-1:0] cmd_wdata,
    output logic [BE_W-1:0]  cmd_be
);
    logic [PA_W-1:0] resv_addr_q;
    key_t            key_q;
    logic            load_req;
    logic            clr_req;
    logic            live;

    // Reserved address capture on LL issue
    always_ff @(posedge clk) begin
        if (!rst_n)
            resv_addr_q <= '0;
        else if (ll_issue_vld)
            resv_addr_q <= ll_issue_addr;
    end

    // Key capture on the first response flit
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= '0;
        else if (ll_rsp_vld)
            key_q <= ll_rsp_key;
    end

    llsc_event_decode #(.PA_W(PA_W)) u_decode (
        .ll_issue_vld (ll_issue_vld),
        .ll_rsp_vld   (ll_rsp_vld),
        .wr_vld       (wr_vld),
        .wr_addr      (wr_addr),
        .atom_vld     (atom_vld),
        .atom_addr    (atom_addr),
        .sw_clr       (sw_clr),
        .resv_addr    (resv_addr_q),
        .load_req     (load_req),
        .clr_req      (clr_req)
    );

    llsc_life_counter #(.TIMEOUT(TIMEOUT)) u_life (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .clr_req  (clr_req),
        .live     (live)
    );

    llsc_sc_cmd #(.PA_W(PA_W)) u_sc (
        .clk           (clk),
        .rst_n         (rst_n),
        .live          (live),
        .resv_addr     (resv_addr_q),
        .resv_key      (key_q),
        .sc_query_vld  (sc_query_vld),
        .sc_query_addr (sc_query_addr),
        .sc_data       (sc_data),
        .sc_flit_sel   (flit_sel_e'(sc_flit_sel)),
        .sc_ok         (sc_ok),
        .sc_fail       (sc_fail),
        .cmd_addr      (cmd_addr),
        .cmd_wdata     (cmd_wdata),
        .cmd_be        (cmd_be)
    );

    // Drive the status outputs
    always_comb begin
        resv_live = live;
        resv_key  = key_q;
    end

    a_r2_issue_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && ll_issue_vld && !ll_rsp_vld |=> !resv_live);
    a_r10_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !ll_rsp_vld |=> $stable(resv_key));
endmodule

// File: tb/llsc_resv_tracker_tb.sv
module llsc_resv_tracker_tb;
    localparam int PA_W = 40;
    localparam int T    = 20;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ll_issue_vld, ll_rsp_vld, wr_vld, atom_vld, sw_clr;
    logic            sc_query_vld, sc_flit_sel;
    logic [PA_W-1:0] ll_issue_addr, wr_addr, atom_addr, sc_query_addr;
    logic [31:0]     ll_rsp_key, sc_data;
    logic            sc_ok, sc_fail, resv_live;
    logic [31:0]     resv_key, cmd_wdata;
    logic [PA_W-1:0] cmd_addr;
    logic [3:0]      cmd_be;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    llsc_resv_tracker #(.PA_W(PA_W), .TIMEOUT(T)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ll_issue_vld(ll_issue_vld), .ll_issue_addr(ll_issue_addr),
        .ll_rsp_vld(ll_rsp_vld), .ll_rsp_key(ll_rsp_key),
        .wr_vld(wr_vld), .wr_addr(wr_addr),
        .atom_vld(atom_vld), .atom_addr(atom_addr),
        .sw_clr(sw_clr),
        .sc_query_vld(sc_query_vld), .sc_query_addr(sc_query_addr),
        .sc_data(sc_data), .sc_flit_sel(sc_flit_sel),
        .sc_ok(sc_ok), .sc_fail(sc_fail), .resv_live(resv_live),
        .resv_key(resv_key), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_be(cmd_be)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ll_issue_vld = 0; ll_rsp_vld = 0; wr_vld = 0; atom_vld = 0; sw_clr = 0;
        sc_query_vld = 0; sc_flit_sel = 0;
        ll_issue_addr = '0; wr_addr = '0; atom_addr = '0; sc_query_addr = '0;
        ll_rsp_key = '0; sc_data = '0;
    endtask

    // One-cycle pulse helpers; each returns at the negedge after the edge
    task automatic do_ll(input logic [PA_W-1:0] a);
        @(negedge clk); ll_issue_vld = 1; ll_issue_addr = a;
        @(negedge clk); ll_issue_vld = 0;
    endtask

    task automatic do_rsp(input logic [31:0] k);
        @(negedge clk); ll_rsp_vld = 1; ll_rsp_key = k;
        @(negedge clk); ll_rsp_vld = 0;
    endtask

    task automatic reserve(input logic [PA_W-1:0] a, input logic [31:0] k);
        do_ll(a);
        do_rsp(k);
    endtask

    task automatic query(input logic [PA_W-1:0] a, output logic ok, output logic fl);
        sc_query_vld = 1; sc_query_addr = a;
        #1; ok = sc_ok; fl = sc_fail;
        sc_query_vld = 0;
    endtask

    task automatic t_reset();
        logic ok, fl;
        check("R1 live after reset", resv_live, 0);
        query(40'h10, ok, fl);
        check("R1 sc_ok after reset", ok, 0);
        check("R1 sc_fail after reset", fl, 1);
    endtask

    task automatic t_basic_sc();
        logic ok, fl;
        reserve(40'h12_3456_7890, 32'hCAFE_0001);
        check("R3 live after response", resv_live, 1);
        check("R10 key stored", resv_key, 32'hCAFE_0001);
        query(40'h12_3456_7890, ok, fl);
        check("R8 match ok", ok, 1);
        check("R8 match fail", fl, 0);
        query(40'h12_3456_7894, ok, fl);
        check("R8 mismatch ok", ok, 0);
        check("R8 mismatch fail", fl, 1);
    endtask

    task automatic t_cmd_fields();
        sc_query_addr = 40'hAB_CDEF_0123; sc_data = 32'h5555_AAAA;
        sc_flit_sel = 0; #1;
        check("R9 key flit", cmd_wdata, 32'hCAFE_0001);
        check("R9 aligned addr", cmd_addr, 40'hAB_CDEF_0120);
        check("R9 byte enables", cmd_be, 4'hF);
        sc_flit_sel = 1; #1;
        check("R9 data flit", cmd_wdata, 32'h5555_AAAA);
        sc_flit_sel = 0; sc_query_addr = '0; sc_data = '0;
    endtask

    task automatic t_lifetime();
        reserve(40'h100, 32'h1111_2222);
        for (int i = 0; i < T - 1; i++) @(negedge clk);
        check("R3 live at last cycle", resv_live, 1);
        @(negedge clk);
        check("R3 expired", resv_live, 0);
        check("R10 key kept after expiry", resv_key, 32'h1111_2222);
    endtask

    task automatic t_write();
        reserve(40'h200, 32'h2);
        @(negedge clk); wr_vld = 1; wr_addr = 40'h204;
        @(negedge clk); wr_vld = 0;
        check("R4 other write ignored", resv_live, 1);
        @(negedge clk); wr_vld = 1; wr_addr = 40'h200;
        @(negedge clk); wr_vld = 0;
        check("R4 matching write clears", resv_live, 0);
    endtask

    task automatic t_atomic();
        reserve(40'h300, 32'h3);
        @(negedge clk); atom_vld = 1; atom_addr = 40'h308;
        @(negedge clk); atom_vld = 0;
        check("R5 other atomic ignored", resv_live, 1);
        @(negedge clk); atom_vld = 1; atom_addr = 40'h300;
        @(negedge clk); atom_vld = 0;
        check("R5 matching atomic clears", resv_live, 0);
    endtask

    task automatic t_swclr();
        reserve(40'h400, 32'h4444);
        @(negedge clk); sw_clr = 1;
        @(negedge clk); sw_clr = 0;
        check("R6 software clear", resv_live, 0);
        check("R10 key kept after clear", resv_key, 32'h4444);
    endtask

    task automatic t_ll_cancel();
        logic ok, fl;
        reserve(40'h500, 32'h5);
        do_ll(40'h600);
        check("R2 new LL cancels", resv_live, 0);
        query(40'h500, ok, fl);
        check("R2 old address refused", ok, 0);
        do_rsp(32'h6);
        query(40'h600, ok, fl);
        check("R2 new address recorded", ok, 1);
    endtask

    task automatic t_priority();
        do_ll(40'h700);
        @(negedge clk); ll_rsp_vld = 1; ll_rsp_key = 32'h7; wr_vld = 1; wr_addr = 40'h700;
        @(negedge clk); ll_rsp_vld = 0; wr_vld = 0;
        check("R7 load beats clear", resv_live, 1);
        for (int i = 0; i < 5; i++) @(negedge clk);
        do_rsp(32'h77);
        for (int i = 0; i < T - 1; i++) @(negedge clk);
        check("R7 reload restarts lifetime", resv_live, 1);
        @(negedge clk);
        check("R7 reload expires", resv_live, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic_sc();
        t_cmd_fields();
        t_lifetime();
        t_write();
        t_atomic();
        t_swclr();
        t_ll_cancel();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule